// File: doc/BRIEF.md
# Single-Bank Open-Row and Auto-Precharge Timer

This block follows one bank of a DDR SDRAM from the controller's side. It sees every command the controller issues to the bank. The commands are row activate, read, write, explicit precharge and burst terminate. Reads and writes carry a flag taken from address bit 10, and that flag asks for a precharge with no extra command. From these commands the block keeps the open/closed state of the bank and the row that is open. It also keeps a busy indication while a burst is moving data.

An implied precharge has no command of its own. The block places it at the earliest legal cycle, which is the later of two points: the end of the burst, and the point where the minimum active time since the activate has passed. From that start it counts the precharge recovery time. It then raises a ready flag, and the arbiter uses that flag to gate the next command to the bank. Other banks are not affected. Arbitration and the data path are handled outside the block.

Top module: `bank_ap_tracker`

## Requirements
- R1: After reset the row is closed, `open_row` is zero, `bank_ready` is high and `burst_busy` is low.
- R2: An activate (`cmd_op` = 1) accepted while `bank_ready` is high and the row is closed sets `row_open` in the next cycle, and `open_row` then holds the `cmd_row` that came with the command.
- R3: An activate is ignored while the row is already open or while `bank_ready` is low. Both `row_open` and `open_row` keep their values.
- R4: A read (`cmd_op` = 2) or a write (`cmd_op` = 3) issued in cycle t drives `burst_busy` high in cycles t+1 to t+BURST_LEN/2-1. The burst counts as complete at cycle t+BURST_LEN/2.
- R5: With `cmd_a10` high on a read or write issued in cycle t, the implied precharge starts in cycle p. Here p is the later of t+BURST_LEN/2 and a+T_RAS, where a is the cycle of the activate. `row_open` falls in cycle p+1, and `bank_ready` is low from t+1.
- R6: After any precharge start in cycle p, `bank_ready` stays low until cycle p+T_RP, and it is high again in that cycle.
- R7: The auto-precharge flag applies to one command only. A read or write with `cmd_a10` low leaves the row open and `bank_ready` high, even when earlier commands had the flag set.
- R8: A burst terminate (`cmd_op` = 5) in cycle b drops `burst_busy` in cycle b+1 and leaves the row open. This happens when the latest read/write was a read with the flag clear and its burst is still busy.
- R9: A burst terminate has no effect after a write, and none while `bank_ready` is low (for example, during an auto-precharge read).
- R10: An explicit precharge (`cmd_op` = 4) accepted while the row is open closes it in the next cycle and clears `burst_busy`. It then follows the R6 timing, with p equal to its issue cycle.
- R11: A precharge to a closed bank does nothing. `bank_ready` stays high and the row stays closed.
- R12: Issuing a read or write while the row is closed or `bank_ready` is low is a protocol violation. `cmd_op` = 0 is no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command code: 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 burst terminate |
| cmd_a10 | input | 1 | Auto-precharge request (address bit 10) for read/write |
| cmd_row | input | ROW_W | Row address for activate |
| row_open | output | 1 | A row is open in the bank |
| open_row | output | ROW_W | Address of the last activated row |
| bank_ready | output | 1 | Bank may accept a command |
| burst_busy | output | 1 | Read/write burst data still transferring |

## Verification
Suppose the tRAS, burst or tRP counter has a wrong value. The fall of `row_open` and the rise of `bank_ready` then move by one or more cycles, and a per-cycle comparison sees this within T_RAS+T_RP cycles of the command. Suppose instead the pending auto-precharge flag or the read-without-flag marker is stale. Then the bank closes when it should not, stays blocked, or ignores a burst terminate, and `row_open`, `bank_ready` or `burst_busy` shows it in the very next cycle.

// File: rtl/bank_ap_pkg.sv
package bank_ap_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_BST = 3'd5
    } bank_op_e;

    // Commands that passed the bank's acceptance rules this cycle
    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic bst;
    } bank_acc_t;

endpackage

// File: rtl/bank_ap_dncnt.sv
// Saturating down-counter: load beats clear, clear beats decrement.
module bank_ap_dncnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clr,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (clr)
            cnt_d = '0;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/bank_ap_decode.sv
// Applies the acceptance rules of the bank to the raw command.
module bank_ap_decode
    import bank_ap_pkg::*;
(
    input  logic [2:0] cmd_op,
    input  logic       ready,
    input  logic       is_open,
    input  logic       last_rd_noap,
    input  logic       busy,
    output bank_acc_t  acc
);
    bank_op_e op;

    always_comb begin
        op      = bank_op_e'(cmd_op);
        acc     = '0;
        acc.act = ready && !is_open && (op == OP_ACT);
        acc.rd  = ready &&  is_open && (op == OP_RD);
        acc.wr  = ready &&  is_open && (op == OP_WR);
        acc.pre = ready &&  is_open && (op == OP_PRE);
        acc.bst = ready && (op == OP_BST) && last_rd_noap && busy;
    end
endmodule

// File: rtl/bank_ap_tracker.sv
module bank_ap_tracker
    import bank_ap_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int BURST_LEN = 8,
    parameter int T_RAS     = 6,
    parameter int T_RP      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_a10,
    input  logic [ROW_W-1:0] cmd_row,
    output logic             row_open,
    output logic [ROW_W-1:0] open_row,
    output logic             bank_ready,
    output logic             burst_busy
);
    localparam int BURST_CYC = BURST_LEN / 2;
    localparam int RAS_W     = $clog2(T_RAS + 1);
    localparam int BUR_W     = $clog2(BURST_CYC + 1);
    localparam int RP_W      = $clog2(T_RP + 1);

    typedef struct packed {
        logic             row_open;
        logic [ROW_W-1:0] open_row;
        logic             ap_pend;
        logic             last_rd_noap;
    } trk_state_t;

    trk_state_t st_d, st_q;
    bank_acc_t  acc;
    logic       ras_zero, bur_zero, rp_zero;
    logic       pc_start;

    assign bank_ready = rp_zero && !st_q.ap_pend;
    assign burst_busy = !bur_zero;
    assign row_open   = st_q.row_open;
    assign open_row   = st_q.open_row;

    bank_ap_decode u_dec (
        .cmd_op       (cmd_op),
        .ready        (bank_ready),
        .is_open      (st_q.row_open),
        .last_rd_noap (st_q.last_rd_noap),
        .busy         (burst_busy),
        .acc          (acc)
    );

    // Implied precharge: flag pending, burst finished and tRAS met.
    assign pc_start = (st_q.ap_pend && bur_zero && ras_zero) || acc.pre;

    bank_ap_dncnt #(.W(RAS_W)) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc.act),
        .load_val (RAS_W'(T_RAS - 1)),
        .clr      (1'b0),
        .zero     (ras_zero)
    );

    bank_ap_dncnt #(.W(BUR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc.rd || acc.wr),
        .load_val (BUR_W'(BURST_CYC - 1)),
        .clr      (acc.bst || acc.pre),
        .zero     (bur_zero)
    );

    bank_ap_dncnt #(.W(RP_W)) u_rp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pc_start),
        .load_val (RP_W'(T_RP - 1)),
        .clr      (1'b0),
        .zero     (rp_zero)
    );

    always_comb begin
        st_d = st_q;
        if (acc.act) begin
            st_d.row_open = 1'b1;
            st_d.open_row = cmd_row;
        end
        if (acc.rd || acc.wr) begin
            st_d.ap_pend      = cmd_a10;
            st_d.last_rd_noap = acc.rd && !cmd_a10;
        end
        if (pc_start) begin
            st_d.row_open     = 1'b0;
            st_d.ap_pend      = 1'b0;
            st_d.last_rd_noap = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bank_ap_tracker_chk.sv
module bank_ap_tracker_chk #(
    parameter int ROW_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cmd_op,
    input logic [ROW_W-1:0] cmd_row,
    input logic             row_open,
    input logic [ROW_W-1:0] open_row,
    input logic             bank_ready,
    input logic             burst_busy
);
    assert_rdwr_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd2 || cmd_op == 3'd3) |-> (row_open && bank_ready));

    assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_ready && !row_open && cmd_op == 3'd1) |=>
        (row_open && open_row == $past(cmd_row)));

    assert_act_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_open && cmd_op == 3'd1) |=> $stable(open_row));

    assert_pre_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_ready && row_open && cmd_op == 3'd4) |=> (!row_open && !burst_busy));

    assert_pre_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_ready && !row_open && cmd_op == 3'd4) |=> (!row_open && bank_ready));

    assert_close_after_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_open) |-> (!$past(burst_busy) || $past(cmd_op) == 3'd4));
endmodule

bind bank_ap_tracker bank_ap_tracker_chk #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_op     (cmd_op),
    .cmd_row    (cmd_row),
    .row_open   (row_open),
    .open_row   (open_row),
    .bank_ready (bank_ready),
    .burst_busy (burst_busy)
);

// File: tb/bank_ap_tracker_tb.sv
module bank_ap_tracker_tb;
    localparam int ROW_W = 13;
    localparam int BL    = 8;
    localparam int BC    = BL / 2;
    localparam int TRAS  = 6;
    localparam int TRP   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cmd_op = 3'd0;
    logic             cmd_a10 = 1'b0;
    logic [ROW_W-1:0] cmd_row = '0;
    logic             row_open, bank_ready, burst_busy;
    logic [ROW_W-1:0] open_row;

    always #10 clk = ~clk;

    bank_ap_tracker #(.ROW_W(ROW_W), .BURST_LEN(BL), .T_RAS(TRAS), .T_RP(TRP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_a10(cmd_a10), .cmd_row(cmd_row),
        .row_open(row_open), .open_row(open_row), .bank_ready(bank_ready),
        .burst_busy(burst_busy)
    );

    int vec = 0, bad = 0;
    string tag = "R1";

    // Reference model state, times in cycles
    int n = 0;
    bit m_open = 0, ap_pend = 0, last_rd = 0;
    int m_row = 0, ras_ok_at = 0, burst_end = 0, p_start = 0, rp_ready_at = 0;

    function automatic bit exp_ready();
        return (n >= rp_ready_at) && !ap_pend;
    endfunction

    task automatic chk(string what, int act, int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s at cycle %0d: got %0d expected %0d", tag, what, n, act, exp);
        end
    endtask

    task automatic step(int op, bit a10, int row);
        bit rdy;
        @(negedge clk);
        chk("row_open", int'(row_open), int'(m_open));
        chk("bank_ready", int'(bank_ready), int'(exp_ready()));
        chk("burst_busy", int'(burst_busy), int'(n < burst_end));
        if (m_open || n == 0) chk("open_row", int'(open_row), m_row);
        rdy = exp_ready();
        if (ap_pend && n >= p_start) begin
            m_open = 0; ap_pend = 0; last_rd = 0; rp_ready_at = n + TRP;
        end else if (rdy) begin
            case (op)
                1: if (!m_open) begin m_open = 1; m_row = row; ras_ok_at = n + TRAS; end
                2, 3: if (m_open) begin
                    burst_end = n + BC;
                    last_rd = (op == 2) && !a10;
                    if (a10) begin
                        ap_pend = 1;
                        p_start = (n + BC > ras_ok_at) ? n + BC : ras_ok_at;
                    end
                end
                4: if (m_open) begin
                    m_open = 0; last_rd = 0; rp_ready_at = n + TRP;
                    if (burst_end > n + 1) burst_end = n + 1;
                end
                5: if (last_rd && n < burst_end) burst_end = n + 1;
                default: ;
            endcase
        end
        cmd_op = 3'(op); cmd_a10 = a10; cmd_row = ROW_W'(row);
        n++;
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) step(0, 0, 0);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 50 && !(exp_ready() && !ap_pend); i++) step(0, 0, 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        tag = "R1";  step(0, 0, 0);
        tag = "R2";  step(1, 0, 'h0A5); idle(2);
        tag = "R7";  step(2, 0, 0); idle(6);           // no flag: row stays open
        tag = "R8";  step(2, 0, 0); step(5, 0, 0); idle(4);
        tag = "R9";  step(3, 0, 0); step(5, 0, 0); idle(4);
        tag = "R10"; step(4, 0, 0); wait_ready(); idle(1);
        tag = "R5";  step(1, 0, 'h111); step(2, 1, 0); // tRAS-bound close
        tag = "R9";  step(5, 0, 0);                    // ignored while not ready
        tag = "R3";  step(1, 0, 'h1FF); idle(2);
        tag = "R6";  wait_ready(); idle(1);
        tag = "R5";  step(1, 0, 'h033); idle(8); step(3, 1, 0); // burst-bound close
        tag = "R6";  wait_ready(); idle(1);
        tag = "R11"; step(4, 0, 0); idle(2);
        tag = "R3";  step(1, 0, 'h044); step(1, 0, 'h055); idle(2);
        tag = "R4";  step(2, 0, 0); idle(BC + 1);
        tag = "R4";  // mixed traffic; R12: READ/WRITE issued only when legal
        for (int i = 0; i < 2000; i++) begin
            int op;
            bit a10;
            op  = int'($urandom_range(0, 5));
            a10 = ($urandom_range(0, 3) == 0);
            if ((op == 2 || op == 3) && !(m_open && exp_ready())) op = 0;
            step(op, a10, int'($urandom_range(0, 8191)));
        end
        idle(20);
        summary();
    end
endmodule